// File: doc/BRIEF.md
# Descriptor-Driven Tensor Tile Copier

This block copies one rectangular tile of a tensor of up to three dimensions from a flat memory into a local scratchpad. The tensor's layout is registered ahead of time in a small table. Each entry holds a base address, a dimension count, and for each dimension an extent, a stride and a tile length. Each entry also holds a fill mode. Each table entry accepts exactly one write after reset. Every later copy of that tensor reuses the entry, so a command carries no element addresses.

A command gives a table index, a tile origin per dimension, a destination scratchpad word address and a barrier tag. It enters a two-slot queue and is acknowledged at once. The transfer then runs in the background. The engine computes every element address itself and issues one read at a time on a simple request/response port. It writes each returned word into the scratchpad. Elements that fall outside the tensor are written with the fill value and never read from memory. After the last word lands, the engine emits a one-cycle completion pulse that carries the barrier tag and the number of bytes moved.

Top module: `ttc_tile_copier`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_req_valid`, `spad_we` and `done_valid` are 0.
- R2: Each table entry accepts the first `cfg_we` write addressed to it after reset. Any later write to the same entry is ignored until the next reset.
- R3: The command queue holds two commands. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 exactly while two accepted commands wait, and it never depends on transfer progress.
- R4: Elements are visited with dimension 0 fastest, then dimension 1, then dimension 2. The k-th visited element (counting from 0) goes to scratchpad word `cmd_dst + k`, modulo 2^SAW.
- R5: The read address of an element is the base plus, for each active dimension d, (origin_d + offset_d) times stride_d, all modulo 2^AW. Origin d sits at bits [8d+7:8d] of `cmd_org`, and size, tile and stride are packed the same way.
- R6: If the coordinate origin_d + offset_d is greater than or equal to size_d in any active dimension, the element is written with the fill value and no read is issued for it.
- R7: In fill mode 0 (`cfg_fill` = 0) the fill value is all zeros. In fill mode 1 it is all ones.
- R8: The active dimensions are 0 to n-1, where n is `cfg_ndim` and the value 0 is read as 1. In inactive dimensions, tile length, size, stride and origin have no effect. A tile length of 0 is read as 1.
- R9: At most one read is outstanding. `mem_req_valid` is a one-cycle pulse, and no new request is made until `mem_rsp_valid`. The response word is written to the scratchpad in the cycle `mem_rsp_valid` is 1.
- R10: One cycle after the last scratchpad write of a command, `done_valid` pulses for one cycle. It carries that command's barrier tag and a byte count equal to the element count times DW/8.
- R11: Commands are executed and completed in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IW | Table entry index |
| cfg_base | input | AW | Tensor base address |
| cfg_ndim | input | NDW | Active dimension count (0 read as 1) |
| cfg_size | input | NDIM*CW | Per-dimension extent |
| cfg_stride | input | NDIM*AW | Per-dimension address stride |
| cfg_tile | input | NDIM*CW | Per-dimension tile length |
| cfg_fill | input | 1 | Fill mode: 0 zeros, 1 ones |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue has a free slot |
| cmd_desc | input | IW | Table entry to use |
| cmd_org | input | NDIM*CW | Tile origin per dimension |
| cmd_dst | input | SAW | First scratchpad word |
| cmd_bar | input | BW | Completion barrier tag |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| spad_we | output | 1 | Scratchpad write strobe |
| spad_addr | output | SAW | Scratchpad word address |
| spad_wdata | output | DW | Scratchpad write data |
| done_valid | output | 1 | Completion pulse |
| done_bar | output | BW | Barrier tag of finished command |
| done_bytes | output | BYW | Bytes moved by finished command |

## Verification
A wrong offset counter or carry shows up at once. The next read address is wrong, or a read appears where a fill write was due, within the same element step. A stale element count shows first as a shifted scratchpad address and then as a wrong byte total on the completion pulse. A lost queue entry or a corrupted latched command shows up as a missing or misordered completion tag at the end of the following transfer. Every read address, scratchpad write and completion is compared against an independently computed stream in the cycle it occurs, so a divergence is caught on the first element where it is visible.

// File: rtl/ttc_pkg.sv
// Shared types for the tile copier: walker state and fill mode encodings.
package ttc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ELEM = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } walk_state_e;

    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_ONES = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/ttc_desc_table.sv
// Tensor layout table. Each entry locks after its first write and stays
// fixed until reset. The read port is combinational.
// Assumes NDESC is a power of two so that every index value names an entry.
module ttc_desc_table #(
    parameter int AW    = 16,
    parameter int CW    = 8,
    parameter int NDIM  = 3,
    parameter int NDESC = 4,
    parameter int IW    = 2,
    parameter int NDW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [AW-1:0]        wr_base,
    input  logic [NDW-1:0]       wr_ndim,
    input  logic [NDIM*CW-1:0]   wr_size,
    input  logic [NDIM*AW-1:0]   wr_stride,
    input  logic [NDIM*CW-1:0]   wr_tile,
    input  logic                 wr_fill,
    input  logic [IW-1:0]        rd_idx,
    output logic [AW-1:0]        rd_base,
    output logic [NDW-1:0]       rd_ndim,
    output logic [NDIM*CW-1:0]   rd_size,
    output logic [NDIM*AW-1:0]   rd_stride,
    output logic [NDIM*CW-1:0]   rd_tile,
    output logic                 rd_fill
);
    logic [NDESC-1:0]       lock_q;
    logic [AW-1:0]          base_q   [NDESC];
    logic [NDW-1:0]         ndim_q   [NDESC];
    logic [NDIM*CW-1:0]     size_q   [NDESC];
    logic [NDIM*AW-1:0]     stride_q [NDESC];
    logic [NDIM*CW-1:0]     tile_q   [NDESC];
    logic [NDESC-1:0]       fill_q;

    for (genvar e = 0; e < NDESC; e++) begin : g_entry
        // Capture the first write to this entry, then hold it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lock_q[e]   <= 1'b0;
                base_q[e]   <= '0;
                ndim_q[e]   <= '0;
                size_q[e]   <= '0;
                stride_q[e] <= '0;
                tile_q[e]   <= '0;
                fill_q[e]   <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(e)) && !lock_q[e]) begin
                lock_q[e]   <= 1'b1;
                base_q[e]   <= wr_base;
                ndim_q[e]   <= wr_ndim;
                size_q[e]   <= wr_size;
                stride_q[e] <= wr_stride;
                tile_q[e]   <= wr_tile;
                fill_q[e]   <= wr_fill;
            end
        end
    end

    assign rd_base   = base_q[rd_idx];
    assign rd_ndim   = ndim_q[rd_idx];
    assign rd_size   = size_q[rd_idx];
    assign rd_stride = stride_q[rd_idx];
    assign rd_tile   = tile_q[rd_idx];
    assign rd_fill   = fill_q[rd_idx];
endmodule

// File: rtl/ttc_cmd_fifo.sv
// Small command queue with a valid/ready write side and a pop read side.
// Ready depends only on occupancy. Assumes DEPTH is a power of two.
module ttc_cmd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_avail,
    input  logic             out_pop,
    output logic [WIDTH-1:0] out_data
);
    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CNTW-1:0]  count_q;
    logic             push, pop;

    assign in_ready  = (count_q != CNTW'(DEPTH));
    assign out_avail = (count_q != '0);
    assign out_data  = slot_q[rd_ptr_q];
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_avail;

    // Store pushed commands in their slots.
    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= in_data;
    end

    // Track the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + PW'(1);
            if (pop)  rd_ptr_q <= rd_ptr_q + PW'(1);
            if (push && !pop)      count_q <= count_q + CNTW'(1);
            else if (pop && !push) count_q <= count_q - CNTW'(1);
        end
    end
endmodule

// File: rtl/ttc_walker.sv
// Tile walker. It takes one command with its layout, visits every tile
// element with dimension 0 fastest, reads in-range elements one at a time,
// writes fill for out-of-range ones, packs results into consecutive
// scratchpad words and then pulses completion.
// Assumes DW is a multiple of 8 and at least 16, and CW < AW.
module ttc_walker
    import ttc_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int CW   = 8,
    parameter int NDIM = 3,
    parameter int SAW  = 10,
    parameter int BW   = 4,
    parameter int NDW  = 2,
    localparam int ELW = NDIM * CW,
    localparam int LB  = $clog2(DW / 8),
    localparam int BYW = ELW + LB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_avail,
    output logic                 cmd_pop,
    input  logic [NDIM*CW-1:0]   cmd_org,
    input  logic [SAW-1:0]       cmd_dst,
    input  logic [BW-1:0]        cmd_bar,
    input  logic [AW-1:0]        d_base,
    input  logic [NDW-1:0]       d_ndim,
    input  logic [NDIM*CW-1:0]   d_size,
    input  logic [NDIM*AW-1:0]   d_stride,
    input  logic [NDIM*CW-1:0]   d_tile,
    input  logic                 d_fill,
    output logic                 mem_req_valid,
    output logic [AW-1:0]        mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [DW-1:0]        mem_rsp_data,
    output logic                 spad_we,
    output logic [SAW-1:0]       spad_addr,
    output logic [DW-1:0]        spad_wdata,
    output logic                 done_valid,
    output logic [BW-1:0]        done_bar,
    output logic [BYW-1:0]       done_bytes
);
    walk_state_e          st_q;
    logic [AW-1:0]        base_q;
    logic [NDW-1:0]       nd_q;
    logic [NDIM*CW-1:0]   size_q, tile_q, org_q, off_q, off_nx;
    logic [NDIM*AW-1:0]   stride_q;
    fill_mode_e           fill_q;
    logic [SAW-1:0]       dst_q;
    logic [BW-1:0]        bar_q;
    logic [ELW-1:0]       cnt_q;

    logic [NDW-1:0]       nd_eff;
    logic [NDIM-1:0]      oob_v, end_v;
    logic [AW-1:0]        term_v [NDIM];
    logic [AW-1:0]        addr;
    logic                 oob_any, last_elem;

    // Clamp the stored dimension count into 1..NDIM.
    always_comb begin
        if (nd_q == '0)                nd_eff = NDW'(1);
        else if (nd_q > NDW'(NDIM))    nd_eff = NDW'(NDIM);
        else                           nd_eff = nd_q;
    end

    for (genvar gd = 0; gd < NDIM; gd++) begin : g_dim
        logic          act;
        logic [CW-1:0] teff;
        logic [CW:0]   coord;
        assign act   = (NDW'(gd) < nd_eff);
        assign teff  = (act && (tile_q[gd*CW +: CW] != '0)) ? tile_q[gd*CW +: CW] : CW'(1);
        assign coord = {1'b0, org_q[gd*CW +: CW]} + {1'b0, off_q[gd*CW +: CW]};
        assign oob_v[gd]  = act && (coord >= {1'b0, size_q[gd*CW +: CW]});
        assign term_v[gd] = act ? (AW'(coord) * stride_q[gd*AW +: AW]) : '0;
        assign end_v[gd]  = (off_q[gd*CW +: CW] == (teff - CW'(1)));
    end

    // Sum the per-dimension terms onto the base address.
    always_comb begin
        addr = base_q;
        for (int d = 0; d < NDIM; d++) addr = addr + term_v[d];
    end

    // Step the offsets with dimension 0 fastest.
    always_comb begin
        logic carry;
        carry  = 1'b1;
        off_nx = off_q;
        for (int d = 0; d < NDIM; d++) begin
            if (carry) begin
                if (end_v[d]) begin
                    off_nx[d*CW +: CW] = '0;
                end else begin
                    off_nx[d*CW +: CW] = off_q[d*CW +: CW] + CW'(1);
                    carry = 1'b0;
                end
            end
        end
    end

    assign oob_any       = |oob_v;
    assign last_elem     = &end_v;
    assign cmd_pop       = (st_q == ST_IDLE) && cmd_avail;
    assign mem_req_valid = (st_q == ST_ELEM) && !oob_any;
    assign mem_req_addr  = addr;
    assign spad_we       = ((st_q == ST_ELEM) && oob_any) || ((st_q == ST_WAIT) && mem_rsp_valid);
    assign spad_wdata    = (st_q == ST_WAIT) ? mem_rsp_data : ((fill_q == FILL_ONES) ? '1 : '0);
    assign spad_addr     = dst_q + SAW'(cnt_q);
    assign done_valid    = (st_q == ST_FIN);
    assign done_bar      = bar_q;
    assign done_bytes    = {cnt_q, {LB{1'b0}}};

    // Sequence the walk: latch the command, step through its elements, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            base_q   <= '0;
            nd_q     <= '0;
            size_q   <= '0;
            stride_q <= '0;
            tile_q   <= '0;
            org_q    <= '0;
            off_q    <= '0;
            fill_q   <= FILL_ZERO;
            dst_q    <= '0;
            bar_q    <= '0;
            cnt_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (cmd_avail) begin
                    base_q   <= d_base;
                    nd_q     <= d_ndim;
                    size_q   <= d_size;
                    stride_q <= d_stride;
                    tile_q   <= d_tile;
                    fill_q   <= fill_mode_e'(d_fill);
                    org_q    <= cmd_org;
                    dst_q    <= cmd_dst;
                    bar_q    <= cmd_bar;
                    off_q    <= '0;
                    cnt_q    <= '0;
                    st_q     <= ST_ELEM;
                end
                ST_ELEM: if (!oob_any) st_q <= ST_WAIT;
                ST_FIN:  st_q <= ST_IDLE;
                default: ;
            endcase
            if (spad_we) begin
                cnt_q <= cnt_q + ELW'(1);
                off_q <= off_nx;
                st_q  <= last_elem ? ST_FIN : ST_ELEM;
            end
        end
    end
endmodule

// File: rtl/ttc_tile_copier.sv
// Top of the tile copier. It connects the layout table, the command
// queue and the walker. The queue head's table index selects the layout
// that the walker latches when it takes the command.
module ttc_tile_copier #(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int CW     = 8,
    parameter int NDIM   = 3,
    parameter int NDESC  = 4,
    parameter int SAW    = 10,
    parameter int BW     = 4,
    parameter int QDEPTH = 2,
    localparam int IW    = $clog2(NDESC),
    localparam int NDW   = $clog2(NDIM + 1),
    localparam int BYW   = NDIM * CW + $clog2(DW / 8),
    localparam int CMDW  = BW + SAW + NDIM * CW + IW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [AW-1:0]        cfg_base,
    input  logic [NDW-1:0]       cfg_ndim,
    input  logic [NDIM*CW-1:0]   cfg_size,
    input  logic [NDIM*AW-1:0]   cfg_stride,
    input  logic [NDIM*CW-1:0]   cfg_tile,
    input  logic                 cfg_fill,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [IW-1:0]        cmd_desc,
    input  logic [NDIM*CW-1:0]   cmd_org,
    input  logic [SAW-1:0]       cmd_dst,
    input  logic [BW-1:0]        cmd_bar,
    output logic                 mem_req_valid,
    output logic [AW-1:0]        mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [DW-1:0]        mem_rsp_data,
    output logic                 spad_we,
    output logic [SAW-1:0]       spad_addr,
    output logic [DW-1:0]        spad_wdata,
    output logic                 done_valid,
    output logic [BW-1:0]        done_bar,
    output logic [BYW-1:0]       done_bytes
);
    logic [CMDW-1:0]      q_head;
    logic                 q_avail, q_pop;
    logic [IW-1:0]        h_desc;
    logic [NDIM*CW-1:0]   h_org;
    logic [SAW-1:0]       h_dst;
    logic [BW-1:0]        h_bar;
    logic [AW-1:0]        t_base;
    logic [NDW-1:0]       t_ndim;
    logic [NDIM*CW-1:0]   t_size, t_tile;
    logic [NDIM*AW-1:0]   t_stride;
    logic                 t_fill;

    assign {h_bar, h_dst, h_org, h_desc} = q_head;

    ttc_cmd_fifo #(.WIDTH(CMDW), .DEPTH(QDEPTH)) i_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cmd_valid),
        .in_ready  (cmd_ready),
        .in_data   ({cmd_bar, cmd_dst, cmd_org, cmd_desc}),
        .out_avail (q_avail),
        .out_pop   (q_pop),
        .out_data  (q_head)
    );

    ttc_desc_table #(
        .AW(AW), .CW(CW), .NDIM(NDIM), .NDESC(NDESC), .IW(IW), .NDW(NDW)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_base   (cfg_base),
        .wr_ndim   (cfg_ndim),
        .wr_size   (cfg_size),
        .wr_stride (cfg_stride),
        .wr_tile   (cfg_tile),
        .wr_fill   (cfg_fill),
        .rd_idx    (h_desc),
        .rd_base   (t_base),
        .rd_ndim   (t_ndim),
        .rd_size   (t_size),
        .rd_stride (t_stride),
        .rd_tile   (t_tile),
        .rd_fill   (t_fill)
    );

    ttc_walker #(
        .AW(AW), .DW(DW), .CW(CW), .NDIM(NDIM), .SAW(SAW), .BW(BW), .NDW(NDW)
    ) i_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_avail     (q_avail),
        .cmd_pop       (q_pop),
        .cmd_org       (h_org),
        .cmd_dst       (h_dst),
        .cmd_bar       (h_bar),
        .d_base        (t_base),
        .d_ndim        (t_ndim),
        .d_size        (t_size),
        .d_stride      (t_stride),
        .d_tile        (t_tile),
        .d_fill        (t_fill),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .spad_we       (spad_we),
        .spad_addr     (spad_addr),
        .spad_wdata    (spad_wdata),
        .done_valid    (done_valid),
        .done_bar      (done_bar),
        .done_bytes    (done_bytes)
    );
endmodule

// File: rtl/ttc_checker.sv
// Port-level protocol checks for the tile copier, bound to its top.
// It assumes the memory answers only while a read is outstanding.
module ttc_checker #(
    parameter int DW  = 32,
    parameter int BYW = 26,
    localparam int LB = $clog2(DW / 8)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cmd_valid,
    input logic           cmd_ready,
    input logic           mem_req_valid,
    input logic           mem_rsp_valid,
    input logic           spad_we,
    input logic           done_valid,
    input logic [BYW-1:0] done_bytes
);
    logic rd_pend_q;

    // Remember whether a read has been issued and not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)             rd_pend_q <= 1'b0;
        else if (mem_req_valid) rd_pend_q <= 1'b1;
        else if (mem_rsp_valid) rd_pend_q <= 1'b0;
    end

    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_ready) |-> $past(cmd_valid));

    assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend_q |-> !mem_req_valid);

    assert_write_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spad_we |-> !mem_req_valid);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(spad_we));

    assert_done_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ((done_bytes != '0) && (done_bytes[LB-1:0] == '0)));
endmodule

bind ttc_tile_copier ttc_checker #(.DW(DW), .BYW(BYW)) i_ttc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .spad_we       (spad_we),
    .done_valid    (done_valid),
    .done_bytes    (done_bytes)
);

// File: tb/test_ttc_tile_copier.sv
`timescale 1ns/1ps
// Bench for the tile copier. A behavioural model builds the expected stream
// of reads, scratchpad writes and completions for each command. A monitor
// compares the ports against that stream on every clock.
module test_ttc_tile_copier;
    localparam int AW = 16, DW = 32, CW = 8, NDIM = 3, NDESC = 4, SAW = 10, BW = 4;
    localparam int IW = 2, NDW = 2, BYW = 26;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n;
    logic                cfg_we, cfg_fill;
    logic [IW-1:0]       cfg_idx;
    logic [AW-1:0]       cfg_base;
    logic [NDW-1:0]      cfg_ndim;
    logic [NDIM*CW-1:0]  cfg_size, cfg_tile;
    logic [NDIM*AW-1:0]  cfg_stride;
    logic                cmd_valid, cmd_ready;
    logic [IW-1:0]       cmd_desc;
    logic [NDIM*CW-1:0]  cmd_org;
    logic [SAW-1:0]      cmd_dst;
    logic [BW-1:0]       cmd_bar;
    logic                mem_req_valid, mem_rsp_valid;
    logic [AW-1:0]       mem_req_addr;
    logic [DW-1:0]       mem_rsp_data;
    logic                spad_we;
    logic [SAW-1:0]      spad_addr;
    logic [DW-1:0]       spad_wdata;
    logic                done_valid;
    logic [BW-1:0]       done_bar;
    logic [BYW-1:0]      done_bytes;

    ttc_tile_copier i_ttc_tile_copier (.*);

    int tests = 0, fails = 0;
    int m_base[4], m_nd[4], m_fill[4];
    int m_size[4][3], m_stride[4][3], m_tile[4][3];
    bit m_lock[4];
    logic [SAW+DW-1:0] sp_q[$];
    string             tg_q[$];
    logic [AW-1:0]     ad_q[$];
    logic [BW+BYW-1:0] dn_q[$];
    int                ne_q[$];
    int  wcnt = 0, mem_lat = 0;
    bit  done_pend = 0, outstanding = 0;

    function automatic logic [DW-1:0] memf(logic [AW-1:0] a);
        return {a ^ 16'hC3C3, a};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory: answers each read after mem_lat extra cycles.
    logic [AW-1:0] raddr;
    int  rcnt;
    bit  rpend = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (!rst_n) rpend = 0;
        else if (rpend) begin
            if (rcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memf(raddr);
                rpend = 0;
            end else rcnt--;
        end else if (mem_req_valid) begin
            rpend = 1; raddr = mem_req_addr; rcnt = mem_lat;
        end
    end

    // Monitor: compare every port event with the model stream.
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            if (done_pend || done_valid) begin
                check(done_valid == done_pend, "R10", "done timing", done_valid, done_pend);
                if (done_valid && dn_q.size() > 0) begin
                    logic [BW+BYW-1:0] e;
                    e = dn_q.pop_front();
                    check({done_bar, done_bytes} == e, "R10", "done tag/bytes", {done_bar, done_bytes}, e);
                end
                done_pend = 0;
            end
            if (mem_req_valid) begin
                check(!outstanding, "R9", "request while outstanding", 1, 0);
                if (ad_q.size() == 0) check(0, "R6", "unexpected read", mem_req_addr, 0);
                else begin
                    logic [AW-1:0] a;
                    a = ad_q.pop_front();
                    check(mem_req_addr == a, "R5", "read address", mem_req_addr, a);
                end
                outstanding = 1;
            end
            if (spad_we) begin
                if (mem_rsp_valid) outstanding = 0;
                if (sp_q.size() == 0) check(0, "R11", "unexpected write", spad_addr, 0);
                else begin
                    logic [SAW+DW-1:0] s;
                    string t;
                    s = sp_q.pop_front();
                    t = tg_q.pop_front();
                    check(spad_addr == s[SAW+DW-1:DW], "R4", "scratchpad address", spad_addr, s[SAW+DW-1:DW]);
                    check(spad_wdata == s[DW-1:0], t, "scratchpad data", spad_wdata, s[DW-1:0]);
                    wcnt++;
                    if (ne_q.size() > 0 && wcnt == ne_q[0]) begin
                        void'(ne_q.pop_front());
                        wcnt = 0;
                        done_pend = 1;
                    end
                end
            end
        end
    end

    task automatic cfg_write(int idx, int base, int nd, int s0, int s1, int s2,
                             int st0, int st1, int st2, int t0, int t1, int t2, int fill);
        @(negedge clk);
        cfg_idx = IW'(idx); cfg_base = AW'(base); cfg_ndim = NDW'(nd);
        cfg_size = {CW'(s2), CW'(s1), CW'(s0)};
        cfg_stride = {AW'(st2), AW'(st1), AW'(st0)};
        cfg_tile = {CW'(t2), CW'(t1), CW'(t0)};
        cfg_fill = fill[0]; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!m_lock[idx]) begin
            m_lock[idx] = 1; m_base[idx] = base; m_nd[idx] = nd; m_fill[idx] = fill;
            m_size[idx] = '{s0, s1, s2}; m_stride[idx] = '{st0, st1, st2}; m_tile[idx] = '{t0, t1, t2};
        end
    endtask

    // Model: the expected element stream of one command.
    task automatic expect_cmd(int di, int o0, int o1, int o2, int dst, int bar);
        int nd, n, te[3], o[3];
        nd = (m_nd[di] == 0) ? 1 : (m_nd[di] > 3 ? 3 : m_nd[di]);
        o = '{o0, o1, o2};
        for (int d = 0; d < 3; d++) te[d] = (d < nd && m_tile[di][d] != 0) ? m_tile[di][d] : 1;
        n = 0;
        for (int z = 0; z < te[2]; z++)
            for (int y = 0; y < te[1]; y++)
                for (int x = 0; x < te[0]; x++) begin
                    int off[3], c, addr;
                    bit oob;
                    logic [DW-1:0] data;
                    off = '{x, y, z}; oob = 0; addr = m_base[di];
                    for (int d = 0; d < nd; d++) begin
                        c = o[d] + off[d];
                        if (c >= m_size[di][d]) oob = 1;
                        addr += c * m_stride[di][d];
                    end
                    if (oob) begin
                        data = m_fill[di] ? '1 : '0;
                        tg_q.push_back(m_fill[di] ? "R7" : "R6");
                    end else begin
                        data = memf(AW'(addr));
                        ad_q.push_back(AW'(addr));
                        tg_q.push_back("R9");
                    end
                    sp_q.push_back({SAW'(dst + n), data});
                    n++;
                end
        ne_q.push_back(n);
        dn_q.push_back({BW'(bar), BYW'(n * 4)});
    endtask

    task automatic drive_cmd(int di, int o0, int o1, int o2, int dst, int bar);
        cmd_desc = IW'(di); cmd_org = {CW'(o2), CW'(o1), CW'(o0)};
        cmd_dst = SAW'(dst); cmd_bar = BW'(bar); cmd_valid = 1'b1;
    endtask

    task automatic send_cmd(int di, int o0, int o1, int o2, int dst, int bar);
        expect_cmd(di, o0, o1, o2, dst, bar);
        @(negedge clk);
        drive_cmd(di, o0, o1, o2, dst, bar);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (sp_q.size() != 0 || ne_q.size() != 0 || done_pend);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "R11", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cmd_valid = 1'b0;
        cfg_idx = '0; cfg_base = '0; cfg_ndim = '0; cfg_size = '0;
        cfg_stride = '0; cfg_tile = '0; cfg_fill = 1'b0;
        cmd_desc = '0; cmd_org = '0; cmd_dst = '0; cmd_bar = '0;
        mem_rsp_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle outputs after reset
        check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        check(spad_we == 1'b0, "R1", "spad_we", spad_we, 0);
        check(done_valid == 1'b0, "R1", "done_valid", done_valid, 0);

        // Layouts: 2-D (third tile length set but inactive), 3-D zero fill,
        // 3-D ones fill with wide strides, 1-D given as count 0.
        cfg_write(0, 'h1000, 2, 10, 6, 0, 1, 10, 0, 4, 3, 5, 0);
        cfg_write(1, 'h2000, 3, 5, 4, 3, 1, 5, 20, 3, 2, 2, 0);
        cfg_write(2, 'h3000, 3, 6, 3, 4, 2, 16, 100, 3, 2, 2, 1);
        cfg_write(3, 'h4000, 0, 7, 1, 1, 3, 0, 0, 4, 9, 9, 0);

        // R4 R5: in-range 2-D tile; R3: ready stays high after acceptance
        send_cmd(0, 2, 1, 7, 'h10, 3);
        #1 check(cmd_ready == 1'b1, "R3", "ready while transfer runs", cmd_ready, 1);
        wait_idle();

        // R6: 3-D tile crossing the edge in every dimension
        send_cmd(1, 3, 3, 2, 'h3F8, 5);
        wait_idle();

        // R7: ones fill with non-unit strides
        send_cmd(2, 4, 0, 2, 'h40, 9);
        wait_idle();

        // R8: 1-D layout, upper origins and tile lengths ignored
        send_cmd(3, 5, 77, 200, 'h80, 1);
        wait_idle();

        // R2: second write to entry 0 must not change its layout
        cfg_write(0, 'h7000, 3, 1, 1, 1, 9, 9, 9, 1, 1, 1, 1);
        send_cmd(0, 6, 3, 0, 'h100, 12);
        wait_idle();

        // R3 R11: queue fills while the engine is busy; order preserved
        mem_lat = 3;
        expect_cmd(1, 0, 0, 0, 'h200, 2);
        expect_cmd(0, 0, 0, 0, 'h220, 4);
        expect_cmd(3, 3, 0, 0, 'h240, 6);
        @(negedge clk); drive_cmd(1, 0, 0, 0, 'h200, 2);
        @(negedge clk); drive_cmd(0, 0, 0, 0, 'h220, 4);
        @(negedge clk); drive_cmd(3, 3, 0, 0, 'h240, 6);
        @(negedge clk); cmd_valid = 1'b0;
        #1 check(cmd_ready == 1'b0, "R3", "ready with two waiting", cmd_ready, 0);
        send_cmd(2, 0, 1, 1, 'h260, 8);
        wait_idle();

        // R9: long memory latency, single outstanding read
        mem_lat = 6;
        send_cmd(1, 1, 1, 0, 'h300, 15);
        wait_idle();

        // R11: nothing left over
        check(sp_q.size() == 0 && ad_q.size() == 0 && dn_q.size() == 0, "R11",
              "leftover expectations", sp_q.size() + ad_q.size() + dn_q.size(), 0);
        summary();
        $finish;
    end
endmodule